// File: doc/BRIEF.md
# Byte-Serial Memory Access Arbiter

This block connects a pipelined core to a memory port that carries only one byte per cycle. Two requesters compete for that port: the instruction-fetch stage and the data-memory stage. The arbiter picks one of them, then steps through the bytes of the access at consecutive addresses. For reads it assembles the returned bytes into a 32-bit word. For data-stage stores it issues only as many byte writes as the store width calls for.

While an access is being served, the arbiter raises a stall request for the requester that owns the port. The pipeline stall logic uses that request to freeze the stage. A one-cycle done pulse tells the owner that its access is complete.

A requester holds its request, address, size and write data steady until it sees its done pulse. It drops the request in the cycle that follows. The memory port model has one cycle of read latency: the byte on `mem_rdata` belongs to the address that was driven in the cycle before.

Top module: `byte_mem_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_stall`, `data_stall`, `fetch_done`, `data_done` and `mem_we` are 0 and `mem_addr` is 0. Reset is synchronous and active high.
- R2: A fetch reads four bytes at A, A+1, A+2 and A+3. It assembles them little-endian: byte A goes to bits 7:0 and byte A+3 goes to bits 31:24. `fetch_done` is high in the 6th cycle after the grant edge.
- R3: When both requests are present while the block is idle, the data stage is granted first. The fetch is served after the data access completes.
- R4: `data_stall` is high exactly in the cycles in which the data stage owns the port, and `fetch_stall` is high exactly in the cycles in which fetch owns the port. The two are never high together, and both are low when the block is idle.
- R5: `mem_we` stays low for the whole of a fetch. Write enable and write data come only from the data-stage request.
- R6: A store issues N byte-write cycles. In write cycle i it drives `mem_addr` = A+i and `mem_wdata` = `data_wdata[8i+7:8i]`. N is `data_size` when that value is 1 to 4; any other value means 4. `data_done` is high in the cycle after the last write, and `mem_we` is low from that cycle on.
- R7: A data-stage load of N bytes (N decoded as in R6) reads N bytes from A upward. Lanes above N-1 in `data_rdata` are 0. `data_done` is high in cycle N+2 after the grant edge.
- R8: An access that has started is not pre-empted. A data request raised during a fetch leaves the fetch timing unchanged and is granted only after the fetch completes.
- R9: Each done pulse lasts one cycle, and no request is granted in that cycle. The assembled word stays stable from the done cycle until the next grant.
- R10: Reset asserted in the middle of an access returns the block to idle. Afterwards a new access runs with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Instruction-fetch request, held until done |
| fetch_addr | input | ADDR_W | Byte address of the instruction |
| fetch_stall | output | 1 | Fetch owns the port; stall the fetch stage |
| fetch_done | output | 1 | One-cycle pulse: fetch complete |
| fetch_word | output | 8*WORD_BYTES | Assembled instruction word |
| data_req | input | 1 | Data-stage request, held until done |
| data_we | input | 1 | 1 for a store, 0 for a load |
| data_size | input | $clog2(WORD_BYTES)+1 | Byte count 1..WORD_BYTES; any other value means a full word |
| data_addr | input | ADDR_W | Byte address of the data access |
| data_wdata | input | 8*WORD_BYTES | Store data, lane i goes to address A+i |
| data_stall | output | 1 | Data stage owns the port; stall the pipeline |
| data_done | output | 1 | One-cycle pulse: data access complete |
| data_rdata | output | 8*WORD_BYTES | Assembled load word, zero-extended |
| mem_addr | output | ADDR_W | Byte address to memory |
| mem_we | output | 1 | Byte write enable to memory |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory, one cycle after its address |

## Verification
The bench counts every cycle from the edge that grants a request. A read of N bytes keeps its stall high for N+1 cycles and raises done in cycle N+2, because each byte returns one cycle after its address. A store of N bytes writes in cycles 1 to N and raises done in cycle N+1. The bench drives inputs on falling edges and samples on the falling edge of every cycle in the window. At each sample it compares the stall, done, write enable, address and byte against the values for that exact cycle number. Stores are checked again by fetching the written bytes back through the port. The bench keeps a shadow copy of memory for this, updated from the requirements, not from what the design drives.

// File: rtl/byte_arb_pkg.sv
package byte_arb_pkg;
  typedef enum logic {
    OWN_FETCH = 1'b0,
    OWN_DATA  = 1'b1
  } owner_e;
endpackage

// File: rtl/byte_arb_grant.sv
module byte_arb_grant
  import byte_arb_pkg::*;
(
  input  logic   idle,
  input  logic   fetch_req,
  input  logic   data_req,
  output logic   grant,
  output owner_e grant_owner
);
  // data stage has strict priority over fetch
  always_comb begin
    grant       = idle && (data_req || fetch_req);
    grant_owner = data_req ? OWN_DATA : OWN_FETCH;
  end
endmodule

// File: rtl/byte_arb_seq.sv
module byte_arb_seq
  import byte_arb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int CNT_W     = $clog2(WORD_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  owner_e            start_owner,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_we,
  input  logic [CNT_W-1:0]  start_len,
  input  logic [WORD_W-1:0] start_wdata,
  output logic              busy,
  output owner_e            owner,
  output logic              is_write,
  output logic [CNT_W-1:0]  cnt,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  len_q;
  logic [WORD_W-1:0] wdata_q;
  logic [CNT_W-1:0]  next_idx;
  logic [WORD_W-1:0] wshift;

  always_comb begin
    next_idx = cnt + ONE;
    wshift   = wdata_q >> (next_idx * BYTE_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      owner     <= OWN_FETCH;
      is_write  <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      base_q    <= '0;
      len_q     <= '0;
      wdata_q   <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        owner     <= start_owner;
        is_write  <= start_we;
        cnt       <= '0;
        base_q    <= start_addr;
        len_q     <= start_len;
        wdata_q   <= start_wdata;
        mem_addr  <= start_addr;
        mem_we    <= start_we;
        mem_wdata <= start_wdata[BYTE_W-1:0];
      end else if (busy) begin
        cnt <= next_idx;
        if (is_write) begin
          if (next_idx == len_q) begin
            busy   <= 1'b0;
            mem_we <= 1'b0;
            done   <= 1'b1;
          end else begin
            mem_addr  <= base_q + ADDR_W'(next_idx);
            mem_wdata <= wshift[BYTE_W-1:0];
          end
        end else begin
          if (cnt == len_q) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (next_idx < len_q) begin
            mem_addr <= base_q + ADDR_W'(next_idx);
          end
        end
      end
    end
  end

  // counter never runs past the access length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= len_q));
  // a write never outlives its length (R6)
  assert_write_len_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy && is_write && cnt < len_q));
endmodule

// File: rtl/byte_arb_assemble.sv
module byte_arb_assemble #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int CNT_W     = $clog2(WORD_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  input  logic              is_write,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0] lane;
  assign lane = cnt - CNT_W'(1);

  // byte from cycle c lands in lane c-1 (one cycle memory latency)
  always_ff @(posedge clk) begin
    if (rst || start) begin
      word <= '0;
    end else if (busy && !is_write && cnt != '0) begin
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (lane == CNT_W'(i)) word[i*BYTE_W +: BYTE_W] <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/byte_mem_arbiter.sv
module byte_mem_arbiter
  import byte_arb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int BYTE_W    = 8,
  localparam int WORD_W    = BYTE_W * WORD_BYTES,
  localparam int SZ_W      = $clog2(WORD_BYTES) + 1,
  localparam int CNT_W     = $clog2(WORD_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_stall,
  output logic              fetch_done,
  output logic [WORD_W-1:0] fetch_word,
  input  logic              data_req,
  input  logic              data_we,
  input  logic [SZ_W-1:0]   data_size,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [WORD_W-1:0] data_wdata,
  output logic              data_stall,
  output logic              data_done,
  output logic [WORD_W-1:0] data_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic             busy, done, is_write, idle, grant;
  owner_e           owner, grant_owner;
  logic [CNT_W-1:0] cnt, start_len, data_len;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] start_addr;
  logic              start_we;

  assign idle = !busy && !done;

  always_comb begin
    if (data_size == '0 || data_size > SZ_W'(WORD_BYTES)) data_len = CNT_W'(WORD_BYTES);
    else data_len = CNT_W'(data_size);
    start_len  = (grant_owner == OWN_DATA) ? data_len : CNT_W'(WORD_BYTES);
    start_addr = (grant_owner == OWN_DATA) ? data_addr : fetch_addr;
    start_we   = (grant_owner == OWN_DATA) && data_we;
  end

  byte_arb_grant u_grant (
    .idle(idle), .fetch_req(fetch_req), .data_req(data_req),
    .grant(grant), .grant_owner(grant_owner)
  );

  byte_arb_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(grant), .start_owner(grant_owner),
    .start_addr(start_addr), .start_we(start_we), .start_len(start_len),
    .start_wdata(data_wdata), .busy(busy), .owner(owner), .is_write(is_write),
    .cnt(cnt), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  byte_arb_assemble #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_asm (
    .clk(clk), .rst(rst), .start(grant), .busy(busy), .is_write(is_write),
    .cnt(cnt), .mem_rdata(mem_rdata), .word(word)
  );

  assign fetch_stall = busy && owner == OWN_FETCH;
  assign data_stall  = busy && owner == OWN_DATA;
  assign fetch_done  = done && owner == OWN_FETCH;
  assign data_done   = done && owner == OWN_DATA;
  assign fetch_word  = word;
  assign data_rdata  = word;

  assert_stall_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(fetch_stall && data_stall));
  assert_fetch_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> !mem_we);
  assert_data_first_R3: assert property (@(posedge clk) disable iff (rst)
    (idle && data_req && fetch_req) |=> (data_stall && !fetch_stall));
  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |=> (fetch_stall || fetch_done));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (fetch_done || data_done) |=> !(fetch_done || data_done));
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (fetch_done || data_done) |=> $stable(word));
endmodule

// File: tb/byte_mem_arbiter_bench.sv
module byte_mem_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0, data_req = 1'b0, data_we = 1'b0;
  logic [31:0] fetch_addr = '0, data_addr = '0, data_wdata = '0;
  logic [2:0]  data_size = 3'd4;
  logic        fetch_stall, fetch_done, data_stall, data_done, mem_we;
  logic [31:0] fetch_word, data_rdata, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  ram [256];
  logic [7:0]  shadow [256];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  byte_mem_arbiter u_byte_mem_arbiter (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_stall(fetch_stall), .fetch_done(fetch_done), .fetch_word(fetch_word),
    .data_req(data_req), .data_we(data_we), .data_size(data_size),
    .data_addr(data_addr), .data_wdata(data_wdata), .data_stall(data_stall),
    .data_done(data_done), .data_rdata(data_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < 256; i++) begin
    ram[i]    = 8'(i * 37 + 11);
    shadow[i] = 8'(i * 37 + 11);
  end

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // one access from an idle block; every cycle of its window is checked
  task automatic access(input bit d, input bit we, input logic [7:0] a,
                        input logic [31:0] wd, input logic [2:0] sz);
    int n, fin;
    logic [31:0] expw, word;
    bit own_st, oth_st, dn;
    n    = d ? ((sz == 0 || sz > 4) ? 4 : int'(sz)) : 4;
    fin  = we ? n : n + 1;
    expw = '0;
    if (!we) for (int i = 0; i < n; i++) expw[8*i +: 8] = shadow[8'(a + 8'(i))];
    if (d) begin
      data_req = 1'b1; data_we = we; data_addr = {24'd0, a}; data_wdata = wd; data_size = sz;
    end else begin
      fetch_req = 1'b1; fetch_addr = {24'd0, a};
    end
    for (int k = 1; k <= fin + 1; k++) begin
      tick();
      own_st = d ? data_stall : fetch_stall;
      oth_st = d ? fetch_stall : data_stall;
      dn     = d ? data_done : fetch_done;
      word   = d ? data_rdata : fetch_word;
      chk(own_st == (k <= fin) && !oth_st, "R4 stall window", {30'd0, oth_st, own_st}, {31'd0, k <= fin});
      chk(dn == (k == fin + 1), d ? (we ? "R6 store done" : "R7 load done") : "R2 fetch done", 32'(dn), 32'(k == fin + 1));
      if (!d) chk(!mem_we, "R5 fetch write enable", 32'(mem_we), 32'd0);
      if (we) begin
        chk(mem_we == (k <= n), "R6 write enable", 32'(mem_we), 32'(k <= n));
        if (k <= n) begin
          chk(mem_addr[7:0] == 8'(a + 8'(k - 1)) && mem_wdata == wd[8*(k-1) +: 8], "R6 write byte",
              {mem_addr[15:0], 8'd0, mem_wdata}, {8'd0, 8'(a + 8'(k - 1)), 8'd0, wd[8*(k-1) +: 8]});
          shadow[8'(a + 8'(k - 1))] = wd[8*(k-1) +: 8];
        end
      end
      if (k == fin + 1) begin
        if (!we) chk(word == expw, d ? "R7 load word" : "R2 fetch word", word, expw);
        fetch_req = 1'b0; data_req = 1'b0;
      end
    end
    tick();
    word = d ? data_rdata : fetch_word;
    chk(!fetch_done && !data_done && (we || word == expw), "R9 pulse and hold", word, expw);
  endtask

  logic [31:0] expf, expd;

  initial begin
    // R1
    tick(); tick();
    chk(!fetch_stall && !data_stall && !fetch_done && !data_done && !mem_we && mem_addr == 0,
        "R1 reset state", {mem_addr[27:0], fetch_stall, data_stall, mem_we, fetch_done}, 32'd0);
    rst = 1'b0;
    tick();
    chk(!fetch_stall && !data_stall && !mem_we, "R1 after reset", {29'd0, fetch_stall, data_stall, mem_we}, 32'd0);

    // R2 sweep over fetch addresses
    for (int a = 0; a < 64; a += 5) access(1'b0, 1'b0, 8'(a), 32'd0, 3'd4);
    access(1'b0, 1'b0, 8'd254, 32'd0, 3'd4);

    // R6 store sizes, read back through fetch
    for (int s = 0; s < 8; s++) begin
      access(1'b1, 1'b1, 8'(100 + 8 * s), 32'hA1B2C3D4 ^ 32'(s * 32'h01010101), 3'(s));
      access(1'b0, 1'b0, 8'(100 + 8 * s), 32'd0, 3'd4);
    end

    // R7 loads of every size
    for (int s = 0; s < 8; s++) access(1'b1, 1'b0, 8'(30 + s), 32'd0, 3'(s));

    // R3 simultaneous requests
    expf = {shadow[13], shadow[12], shadow[11], shadow[10]};
    expd = {shadow[43], shadow[42], shadow[41], shadow[40]};
    fetch_req = 1'b1; fetch_addr = 32'd10;
    data_req = 1'b1; data_we = 1'b0; data_addr = 32'd40; data_size = 3'd4;
    tick();
    chk(data_stall && !fetch_stall, "R3 data granted first", {30'd0, data_stall, fetch_stall}, 32'd2);
    for (int k = 0; k < 20 && !data_done; k++) begin
      chk(!fetch_stall, "R3 fetch waits", 32'(fetch_stall), 32'd0);
      tick();
    end
    chk(data_done && data_rdata == expd, "R3 data word", data_rdata, expd);
    data_req = 1'b0;
    tick();
    chk(!fetch_stall && !data_stall, "R9 no grant in done cycle", {30'd0, fetch_stall, data_stall}, 32'd0);
    tick();
    chk(fetch_stall, "R3 fetch served after", 32'(fetch_stall), 32'd1);
    for (int k = 0; k < 20 && !fetch_done; k++) tick();
    chk(fetch_done && fetch_word == expf, "R3 fetch word", fetch_word, expf);
    fetch_req = 1'b0;
    tick(); tick();

    // R8 data request during a fetch
    expf = {shadow[23], shadow[22], shadow[21], shadow[20]};
    fetch_req = 1'b1; fetch_addr = 32'd20;
    tick(); tick();
    data_req = 1'b1; data_we = 1'b1; data_addr = 32'd200; data_wdata = 32'h5566_7788; data_size = 3'd2;
    for (int k = 3; k <= 6; k++) begin
      tick();
      chk(!data_stall && fetch_stall == (k <= 5) && fetch_done == (k == 6), "R8 fetch not pre-empted",
          {29'd0, data_stall, fetch_stall, fetch_done}, {30'd0, k <= 5, k == 6});
    end
    chk(fetch_word == expf, "R8 fetch word", fetch_word, expf);
    fetch_req = 1'b0;
    tick(); tick();
    chk(data_stall && mem_we && mem_addr[7:0] == 8'd200 && mem_wdata == 8'h88, "R8 store follows",
        {mem_addr[7:0], mem_wdata, 14'd0, data_stall, mem_we}, {8'd200, 8'h88, 16'd3});
    shadow[200] = 8'h88; shadow[201] = 8'h77;
    for (int k = 0; k < 10 && !data_done; k++) tick();
    data_req = 1'b0;
    tick();

    // R10 reset mid-access
    fetch_req = 1'b1; fetch_addr = 32'd60;
    tick(); tick();
    rst = 1'b1; fetch_req = 1'b0;
    tick();
    rst = 1'b0;
    chk(!fetch_stall && !fetch_done && !mem_we, "R10 reset mid-access",
        {29'd0, fetch_stall, fetch_done, mem_we}, 32'd0);
    access(1'b0, 1'b0, 8'd200, 32'd0, 3'd4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end
endmodule